// File: doc/BRIEF.md
# Serial Register Port with Coherent Time Snapshot

This block is the two-wire serial slave that fronts a calendar clock core. It oversamples the bus clock and data lines with a fast system clock, recognises start and stop conditions, matches a 7-bit device address, and answers through an open-drain pull-down enable. Behind the bus sits a 64-byte register space. A single pointer, set by the first data byte of a write, walks through it and steps by one after every byte in either direction.

The low eight locations belong to the clock core. Reads of them come from a shadow copy of the core's live time bytes. That copy is refreshed at every start condition, at every stop condition, and whenever the pointer rolls over to 00h. A multibyte read therefore sees one coherent instant even while the core keeps counting. Writes to those locations leave the block as a one-cycle strobe with address and data. The remaining 56 locations are general-purpose storage held inside the block. A power-fail inhibit input shuts the bus out of the register space.

Top module: `i2c_snapreg_slave`

## Requirements
- R1: After reset the block does not pull SDA low and issues no write strobe, the pointer is 00h, and every storage location 08h–3Fh reads 00h.
- R2: An address byte whose upper seven bits are 1101000 is acknowledged by pulling SDA low in the ninth clock. Its lowest bit selects the direction: 0 = write, 1 = read.
- R3: An address byte with any other upper seven bits is not acknowledged, and the block keeps SDA released until the next start condition.
- R4: In a write, the first byte after the address loads the pointer from its low six bits. Every later byte is stored at the pointer, and the pointer then steps by one.
- R5: Locations 08h–3Fh are internal storage: a byte written there reads back unchanged.
- R6: A byte written to 00h–07h produces exactly one single-cycle write strobe carrying that location and the byte. The strobe falls while SCL is high in the acknowledge clock of that byte.
- R7: Reads of 00h–07h return the shadow copy. The copy is taken from the live time input at every start, every stop and every pointer rollover to 00h; a live change in the middle of a read is not seen.
- R8: A read starts at the current pointer, whether or not a pointer write preceded it. Bits leave MSB first and change only while SCL is low. The pointer steps after every byte sent, including the last one.
- R9: The pointer rolls over from 3Fh to 00h, for writes and for reads alike.
- R10: A not-acknowledge from the master after a read byte ends the read. The block then releases SDA and keeps it released until the next start.
- R11: While the power-fail inhibit is high, neither address bytes nor data bytes are acknowledged, and no data byte is committed.
- R12: A repeated start in the middle of a transfer restarts address reception and keeps the pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| pf_inhibit_i | input | 1 | Power-fail inhibit, blocks register access |
| live_time_i | input | 64 | Live time bytes from the clock core, location n at bits 8n+7:8n |
| wr_stb_o | output | 1 | One-cycle strobe for a write to 00h–07h |
| wr_addr_o | output | 3 | Location of the strobed write |
| wr_data_o | output | 8 | Byte of the strobed write |

## Verification
A pointer that steps wrongly shows up at once: the next byte read back differs from the model. A stale or badly timed shadow copy shows up in the first time byte read after a start, a stop or a rollover. A state machine that loses its place drives SDA in a clock where the bench expects the line to be released, and the every-clock comparison catches this within a few system cycles. Misrouted commits appear as an unexpected or missing strobe, or as a storage byte that later reads back wrong.

// File: rtl/i2c_snap_pkg.sv
// Shared types for the serial register port.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package i2c_snap_pkg;

    // Bit-level phase of the slave.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } eng_state_t;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_PTR,
        ROLE_DATA
    } byte_role_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL and SDA into the system clock and flags bus events.
// Assumes: system clock at least ~10x SCL; STAGES >= 2; idle bus is high.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_d, sda_d;
    logic              scl_s;

    // Synchroniser chains plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    assign scl_s      = scl_p[STAGES-1];
    assign sda_o      = sda_p[STAGES-1];
    assign scl_rise_o = scl_s & ~scl_d;
    assign scl_fall_o = ~scl_s & scl_d;
    assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
    assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/i2c_byte_engine.sv
// Bit and byte sequencing of the slave: address match, ACK/NACK,
// transmit shifting and the commit pulses for the register space.
// Assumes: events come from i2c_line_sync; rd_byte_i is valid one cycle
// after any pointer change.
module i2c_byte_engine
    import i2c_snap_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       sda_i,
    input  logic       blocked_i,
    input  logic [7:0] rd_byte_i,
    output logic       sda_oe_o,
    output logic       ptr_load_o,
    output logic       data_wr_o,
    output logic       rd_adv_o,
    output logic [7:0] rx_byte_o
);

    eng_state_t state;
    byte_role_t role;
    logic [2:0] cnt;
    logic       full;
    logic       is_read;
    logic       mack;
    logic [7:0] shreg;
    logic [7:0] tx;

    assign rx_byte_o = shreg;

    // Main sequencer: bus events drive state, SDA enable and commit pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            role       <= ROLE_ADDR;
            cnt        <= '0;
            full       <= 1'b0;
            is_read    <= 1'b0;
            mack       <= 1'b0;
            shreg      <= '0;
            tx         <= '0;
            sda_oe_o   <= 1'b0;
            ptr_load_o <= 1'b0;
            data_wr_o  <= 1'b0;
            rd_adv_o   <= 1'b0;
        end else begin
            ptr_load_o <= 1'b0;
            data_wr_o  <= 1'b0;
            rd_adv_o   <= 1'b0;
            if (start_i) begin
                state    <= ST_RX;
                role     <= ROLE_ADDR;
                cnt      <= '0;
                full     <= 1'b0;
                sda_oe_o <= 1'b0;
            end else if (stop_i) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise_i) begin
                            shreg <= {shreg[6:0], sda_i};
                            cnt   <= cnt + 3'd1;
                            if (cnt == 3'd7) full <= 1'b1;
                        end else if (scl_fall_i && full) begin
                            full <= 1'b0;
                            if (blocked_i) begin
                                state <= ST_IDLE;
                            end else if (role != ROLE_ADDR) begin
                                sda_oe_o <= 1'b1;
                                state    <= ST_RX_ACK;
                            end else if (shreg[7:1] == DEV_ADDR) begin
                                sda_oe_o <= 1'b1;
                                is_read  <= shreg[0];
                                state    <= ST_RX_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_rise_i) begin
                            ptr_load_o <= (role == ROLE_PTR);
                            data_wr_o  <= (role == ROLE_DATA);
                        end else if (scl_fall_i) begin
                            cnt <= '0;
                            if (role == ROLE_ADDR && is_read) begin
                                tx       <= rd_byte_i;
                                sda_oe_o <= ~rd_byte_i[7];
                                state    <= ST_TX;
                            end else begin
                                sda_oe_o <= 1'b0;
                                role     <= (role == ROLE_ADDR) ? ROLE_PTR : ROLE_DATA;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall_i) begin
                            if (cnt == 3'd7) begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_TX_ACK;
                            end else begin
                                tx       <= {tx[6:0], 1'b0};
                                sda_oe_o <= ~tx[6];
                                cnt      <= cnt + 3'd1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise_i) begin
                            rd_adv_o <= 1'b1;
                            mack     <= ~sda_i;
                        end else if (scl_fall_i) begin
                            cnt <= '0;
                            if (mack) begin
                                tx       <= rd_byte_i;
                                sda_oe_o <= ~rd_byte_i[7];
                                state    <= ST_TX;
                            end else begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe_o <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R8: the SDA enable moves only after an SCL fall or a start/stop event.
    p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $past(scl_fall_i || start_i || stop_i));

    // R6: commits are issued on the rising edge of the acknowledge clock.
    p_commit_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load_o || data_wr_o) |-> $past(scl_rise_i));

    // R11: with the inhibit high a completed byte is never acknowledged.
    p_block_nack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked_i && state == ST_RX && full && scl_fall_i && !start_i && !stop_i)
        |=> !sda_oe_o);

    // R10: a master NACK leaves the slave idle with SDA released.
    p_nack_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK && scl_fall_i && !mack && !start_i && !stop_i)
        |=> (!sda_oe_o && state == ST_IDLE));

    // R4: at most one register-space command per cycle.
    p_one_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ptr_load_o, data_wr_o, rd_adv_o}));

endmodule

// File: rtl/i2c_reg_space.sv
// Register pointer, time shadow copy, internal storage and write strobes.
// Assumes: REG_BYTES and TIME_BYTES are powers of two, TIME_BYTES < REG_BYTES.
module i2c_reg_space #(
    parameter int REG_BYTES  = 64,
    parameter int TIME_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          snap_req_i,
    input  logic                          ptr_load_i,
    input  logic                          data_wr_i,
    input  logic                          rd_adv_i,
    input  logic [7:0]                    rx_byte_i,
    input  logic [TIME_BYTES*8-1:0]       live_time_i,
    output logic [7:0]                    rd_byte_o,
    output logic                          wr_stb_o,
    output logic [$clog2(TIME_BYTES)-1:0] wr_addr_o,
    output logic [7:0]                    wr_data_o
);

    localparam int             PW     = $clog2(REG_BYTES);
    localparam int             TAW    = $clog2(TIME_BYTES);
    localparam logic [PW-1:0]  LAST_P = PW'(REG_BYTES - 1);
    localparam logic [PW-1:0]  TB_P   = PW'(TIME_BYTES);

    logic [PW-1:0]           ptr_q;
    logic [TIME_BYTES*8-1:0] shadow_q;
    logic [7:0]              ram [TIME_BYTES:REG_BYTES-1];
    logic                    adv, wrap, in_time;

    assign adv     = data_wr_i | rd_adv_i;
    assign wrap    = adv && (ptr_q == LAST_P);
    assign in_time = (ptr_q < TB_P);

    // Pointer: loaded by the first write byte, stepped after each data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr_q <= '0;
        else if (ptr_load_i) ptr_q <= rx_byte_i[PW-1:0];
        else if (adv)        ptr_q <= wrap ? '0 : ptr_q + 1'b1;
    end

    // Shadow copy of the live time bytes for coherent reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                  shadow_q <= '0;
        else if (snap_req_i || wrap) shadow_q <= live_time_i;
    end

    // Internal storage for the locations above the time bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = TIME_BYTES; i < REG_BYTES; i++) ram[i] <= '0;
        end else if (data_wr_i && !in_time) begin
            ram[ptr_q] <= rx_byte_i;
        end
    end

    // Write strobe toward the clock core for time-byte commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb_o  <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_stb_o <= data_wr_i && in_time;
            if (data_wr_i && in_time) begin
                wr_addr_o <= ptr_q[TAW-1:0];
                wr_data_o <= rx_byte_i;
            end
        end
    end

    // Read multiplexer: shadow for time bytes, storage otherwise.
    always_comb begin
        if (in_time) rd_byte_o = shadow_q[{ptr_q[TAW-1:0], 3'b000} +: 8];
        else         rd_byte_o = ram[ptr_q];
    end

    // R9: stepping past the last location returns the pointer to zero.
    p_ptr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ptr_load_i && ptr_q == LAST_P) |=> (ptr_q == '0));

    // R7: after a start/stop or a rollover the shadow holds the live bytes.
    p_snap_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_req_i || wrap) |=> (shadow_q == $past(live_time_i)));

    // R4: a plain step moves the pointer by exactly one.
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ptr_load_i && ptr_q != LAST_P) |=> (ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/i2c_snapreg_slave.sv
// Top level: two-wire slave giving access to a 64-byte register space with
// a snapshot of the clock core's time bytes.
// Assumes: pf_inhibit_i and live_time_i are synchronous to clk; SDA is an
// open-drain line pulled low while sda_oe_o is high.
module i2c_snapreg_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         REG_BYTES   = 64,
    parameter int         TIME_BYTES  = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          sda_oe_o,
    input  logic                          pf_inhibit_i,
    input  logic [TIME_BYTES*8-1:0]       live_time_i,
    output logic                          wr_stb_o,
    output logic [$clog2(TIME_BYTES)-1:0] wr_addr_o,
    output logic [7:0]                    wr_data_o
);

    logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic       ptr_load, data_wr, rd_adv;
    logic [7:0] rx_byte, rd_byte;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    i2c_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .sda_i      (sda_s),
        .blocked_i  (pf_inhibit_i),
        .rd_byte_i  (rd_byte),
        .sda_oe_o   (sda_oe_o),
        .ptr_load_o (ptr_load),
        .data_wr_o  (data_wr),
        .rd_adv_o   (rd_adv),
        .rx_byte_o  (rx_byte)
    );

    i2c_reg_space #(.REG_BYTES(REG_BYTES), .TIME_BYTES(TIME_BYTES)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .snap_req_i  (start_ev | stop_ev),
        .ptr_load_i  (ptr_load),
        .data_wr_i   (data_wr),
        .rd_adv_i    (rd_adv),
        .rx_byte_i   (rx_byte),
        .live_time_i (live_time_i),
        .rd_byte_o   (rd_byte),
        .wr_stb_o    (wr_stb_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o)
    );

endmodule

// File: tb/sim_i2c_snapreg_slave.sv
`timescale 1ns/1ps
module sim_i2c_snapreg_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        pf = 1'b0;
    logic [63:0] live = 64'h0706050403020100;
    logic        sda_oe, wr_stb;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        sda_bus;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   quiet = 1'b0;
    bit   done  = 1'b0;

    logic [7:0]  ref_ram [0:63];
    logic [7:0]  snap [0:7];
    int          ref_ptr = 0;
    logic [10:0] exp_wr [$];

    always #4 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_snapreg_slave u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (sda_bus),
        .sda_oe_o     (sda_oe),
        .pf_inhibit_i (pf),
        .live_time_i  (live),
        .wr_stb_o     (wr_stb),
        .wr_addr_o    (wr_addr),
        .wr_data_o    (wr_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic take_snap();
        for (int i = 0; i < 8; i++) snap[i] = live[i*8 +: 8];
    endtask

    task automatic adv_ptr();
        ref_ptr = (ref_ptr == 63) ? 0 : ref_ptr + 1;
        if (ref_ptr == 0) take_snap();
    endtask

    function automatic logic [7:0] exp_rd();
        return (ref_ptr < 8) ? snap[ref_ptr] : ref_ram[ref_ptr];
    endfunction

    task automatic qw();
        repeat (8) @(posedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
        take_snap();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw(); qw();
        take_snap();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
        end
        m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
        ack = ~sda_bus;
        qw(); m_scl = 1'b0; qw();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw(); m_scl = 1'b1; qw(); b[i] = sda_bus; qw(); m_scl = 1'b0;
        end
        qw();
        m_sda = mack ? 1'b0 : 1'b1;
        qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
        m_sda = 1'b1;
    endtask

    task automatic addr(input bit rd, input bit exp_ack, input string tag);
        bit a;
        send_byte({7'h68, rd}, a);
        chk(a == exp_ack, tag, a, exp_ack);
    endtask

    task automatic w_ptr(input logic [7:0] p, input string tag);
        bit a;
        send_byte(p, a);
        chk(a, tag, a, 1);
        ref_ptr = p[5:0];
    endtask

    task automatic w_data(input logic [7:0] d, input string tag);
        bit a;
        if (ref_ptr < 8) exp_wr.push_back({ref_ptr[2:0], d});
        else             ref_ram[ref_ptr] = d;
        send_byte(d, a);
        chk(a, tag, a, 1);
        adv_ptr();
    endtask

    task automatic r_byte(input bit last, input string tag);
        logic [7:0] e, got;
        e = exp_rd();
        recv_byte(!last, got);
        chk(got == e, tag, got, e);
        adv_ptr();
    endtask

    // Every-clock comparison: write strobes against the model queue, SDA silence.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wr_stb) begin
                if (exp_wr.size() == 0) begin
                    chk(0, "R6 unexpected strobe", {wr_addr, wr_data}, 0);
                end else begin
                    logic [10:0] e;
                    e = exp_wr.pop_front();
                    chk({wr_addr, wr_data} == e, "R6 strobe addr/data", {wr_addr, wr_data}, e);
                    chk(m_scl == 1'b1, "R6 strobe in ACK clock high", m_scl, 1);
                end
            end
            if (quiet) chk(!sda_oe, "R3/R10 SDA must stay released", sda_oe, 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        bit a;
        for (int i = 0; i < 64; i++) ref_ram[i] = 8'h00;
        take_snap();
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        chk(!sda_oe, "R1 sda_oe after reset", sda_oe, 0);
        chk(!wr_stb, "R1 wr_stb after reset", wr_stb, 0);

        // R1/R8: read with no pointer write starts at 00h
        bus_start(); addr(1, 1, "R2 read address ack");
        r_byte(0, "R8 first read at reset pointer"); r_byte(1, "R8 second read byte");
        bus_stop();

        // R1/R5: storage reads zero after reset
        bus_start(); addr(0, 1, "R2 write address ack"); w_ptr(8'h3A, "R4 pointer ack");
        bus_start(); addr(1, 1, "R12 read after repeated start");
        r_byte(1, "R1 storage zero after reset");
        bus_stop();

        // R4/R5: multi-byte write into storage, then read back with repeated start
        bus_start(); addr(0, 1, "R2 write address ack"); w_ptr(8'h10, "R4 pointer ack");
        w_data(8'hA5, "R4 data ack"); w_data(8'h3C, "R4 data ack"); w_data(8'h81, "R4 data ack");
        bus_stop();
        bus_start(); addr(0, 1, "R2 write address ack"); w_ptr(8'h10, "R12 pointer set");
        bus_start(); addr(1, 1, "R12 read address ack");
        r_byte(0, "R5 readback"); r_byte(0, "R5 readback"); r_byte(1, "R5 readback");
        bus_stop();

        // R6: writes to time locations become strobes; upper pointer bits ignored
        bus_start(); addr(0, 1, "R2 write address ack"); w_ptr(8'hC2, "R4 pointer low bits");
        w_data(8'h45, "R6 time write"); w_data(8'h12, "R6 time write");
        bus_stop();

        // R7: live change mid-read is not seen
        live = 64'h1111111111111111;
        bus_start(); addr(0, 1, "R2 write address ack"); w_ptr(8'h00, "R4 pointer ack");
        bus_stop();
        live = 64'h8877665544332211;
        bus_start(); addr(1, 1, "R2 read address ack");
        r_byte(0, "R7 shadow byte0");
        live = 64'hFFEEDDCCBBAA9988;
        r_byte(0, "R7 shadow byte1"); r_byte(0, "R7 shadow byte2"); r_byte(1, "R7 shadow byte3");
        bus_stop();

        // R9: write rollover 3Fh -> 00h (wrap also refreshes shadow)
        bus_start(); addr(0, 1, "R2 write address ack"); w_ptr(8'h3E, "R9 pointer ack");
        w_data(8'h11, "R9 write 3E"); w_data(8'h22, "R9 write 3F"); w_data(8'h33, "R9 write wraps to 00");
        bus_stop();

        // R7/R9: read rollover picks up the live value at the wrap
        bus_start(); addr(0, 1, "R2 write address ack"); w_ptr(8'h3F, "R9 pointer ack");
        bus_stop();
        bus_start();
        live = 64'h0102030405060708;
        addr(1, 1, "R2 read address ack");
        r_byte(0, "R9 read at 3F"); r_byte(0, "R7 snapshot on rollover"); r_byte(1, "R9 read at 01");
        bus_stop();

        // R3: foreign address is ignored
        bus_start(); quiet = 1'b1;
        send_byte(8'hA0, a); chk(!a, "R3 foreign address not acked", a, 0);
        send_byte(8'hFF, a); chk(!a, "R3 no ack to later byte", a, 0);
        bus_stop(); quiet = 1'b0;

        // R11: inhibit blocks address and data
        pf = 1'b1;
        bus_start(); quiet = 1'b1; addr(0, 0, "R11 address not acked when inhibited");
        bus_stop(); quiet = 1'b0; pf = 1'b0;
        bus_start(); addr(0, 1, "R2 write address ack"); w_ptr(8'h10, "R11 pointer ack");
        pf = 1'b1;
        send_byte(8'h5A, a); chk(!a, "R11 data not acked when inhibited", a, 0);
        pf = 1'b0;
        bus_stop();
        bus_start(); addr(1, 1, "R2 read address ack");
        r_byte(1, "R11 location unchanged");
        bus_stop();

        // R10: NACK ends read, SDA released while SCL keeps toggling
        bus_start(); addr(0, 1, "R2 write address ack"); w_ptr(8'h10, "R10 pointer ack");
        bus_start(); addr(1, 1, "R2 read address ack");
        r_byte(0, "R10 read byte"); r_byte(1, "R10 last byte");
        quiet = 1'b1;
        for (int k = 0; k < 3; k++) begin
            qw(); m_scl = 1'b1; qw(); m_scl = 1'b0;
        end
        qw();
        bus_stop(); quiet = 1'b0;
        // R8: pointer stepped past the NACKed byte
        bus_start(); addr(1, 1, "R2 read address ack");
        r_byte(1, "R8 pointer stepped after last byte");
        bus_stop();

        repeat (20) @(posedge clk);
        chk(exp_wr.size() == 0, "R6 all expected strobes seen", exp_wr.size(), 0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule